// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Controller

This block gives software control over a set of general-purpose pins, up to 31 lines, through a plain 32-bit register bus with an address, write strobe, write data, read strobe and read data. Each line has its own direction bit and its own output-latch bit. The latch is never written whole: one register address turns latch bits on and another turns them off, so two agents can change different lines without a read-modify-write race. Every pin level passes through a two-stage synchronizer and can be read back.

Each line can also raise an interrupt. A type bit picks level or edge detection, and a polarity bit picks the active level or edge direction. Detection is gated twice. The enable bit decides whether a line's condition is captured and shown in the pending register. The mask bit only decides whether a pending line may drive the shared interrupt output. Edge events stay latched until software acknowledges them; level conditions follow the pin. A build-time parameter sets the line count, and another parameter reverses the meaning of a direction bit.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register byte offsets are: direction 0x00, input 0x04, set 0x0C, clear 0x10, enable 0x14, type 0x18, polarity 0x1C, pending 0x20, mask 0x24. Bit n belongs to line n. Any other offset, and any bit at or above NUM_LINES, reads as 0. Read data appears on the clock edge that samples the read strobe.
- R2: With DIR_INVERT=0, a direction bit of 1 drives that line's output enable high. With DIR_INVERT=1, a direction bit of 1 makes the line an input, so its output enable is low. Writing the direction register takes effect on the next edge.
- R3: Writing the set offset turns on exactly the latch bits written as 1. Bits written as 0 keep their value. Reading the set offset or the clear offset returns the output latch, and the latch drives the output pins.
- R4: Writing the clear offset turns off exactly the latch bits written as 1. Bits written as 0 keep their value.
- R5: The input register returns the pin levels after two synchronizing flops.
- R6: Type bit 1 selects level detection. While the line is enabled, its pending bit is 1 exactly while the synchronized pin equals its polarity bit (1 means active-high, 0 means active-low). Writing 1 to that pending bit does not clear it.
- R7: Type bit 0 selects edge detection. Polarity 1 detects a rising edge and polarity 0 a falling edge. A detected edge on an enabled line sets its pending bit, which then holds until software writes 1 to that bit of the pending register. The opposite edge sets nothing.
- R8: A line whose enable bit is 0 shows no pending bit and captures no edge. A latched edge is dropped when the line is disabled.
- R9: The interrupt output is a register fed by the OR over all lines of pending AND enable AND mask. A pending line with mask 0 is visible in the pending register but does not assert the output.
- R10: After reset, every register reads 0, the latch and interrupt output are 0, and output enables are all low (DIR_INVERT=0) or all high (DIR_INVERT=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_LINES | Pin levels from the pads |
| pin_out | output | NUM_LINES | Output latch value |
| pin_oe | output | NUM_LINES | Per-line output enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench walks every line through all four type and polarity combinations. A design that mixes up the polarity would flag the wrong level or edge. A design that latches level conditions would keep them pending after the pin goes inactive. A design that cannot acknowledge edges, or that catches the opposite edge, leaves a stale pending bit. Set and clear writes are swept over every latch pattern, so a design that writes the latch whole loses bits written as 0. A second instance with the inverted direction sense shows whether the parameter reverses output enables. The bench also checks the enable and mask gates one at a time: a design that merges the two either hides a masked pending line or lets it drive the interrupt output.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_W     = 32;
    localparam int MAX_LINES = 31;

    // byte offsets software depends on
    localparam logic [7:0] OFF_DIR  = 8'h00;
    localparam logic [7:0] OFF_IN   = 8'h04;
    localparam logic [7:0] OFF_SET  = 8'h0C;
    localparam logic [7:0] OFF_CLR  = 8'h10;
    localparam logic [7:0] OFF_EN   = 8'h14;
    localparam logic [7:0] OFF_TYPE = 8'h18;
    localparam logic [7:0] OFF_POL  = 8'h1C;
    localparam logic [7:0] OFF_PEND = 8'h20;
    localparam logic [7:0] OFF_MASK = 8'h24;

    typedef struct packed {
        logic [REG_W-1:0] dir;
        logic [REG_W-1:0] outl;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] typ;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] rdata;
        logic             irq;
    } ctrl_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;

endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic prev_i,
    input  logic en_i,
    input  logic level_i,
    input  logic pol_i,
    input  logic ack_i,
    output logic pend_o
);

    logic edge_d, edge_q;
    logic rise, fall, edge_hit, level_hit;

    always_comb begin
        rise      = sync_i & ~prev_i;
        fall      = ~sync_i & prev_i;
        edge_hit  = pol_i ? rise : fall;
        level_hit = (sync_i == pol_i);

        edge_d = edge_q;
        if (!en_i || level_i) begin
            edge_d = 1'b0;
        end else if (edge_hit) begin
            edge_d = 1'b1;
        end else if (ack_i) begin
            edge_d = 1'b0;
        end

        pend_o = en_i & (level_i ? level_hit : edge_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
        end else begin
            edge_q <= edge_d;
        end
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter bit DIR_INVERT = 1'b0,
    parameter int ADDR_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_re,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);

    localparam logic [REG_W-1:0] LINE_MASK =
        REG_W'((64'd1 << NUM_LINES) - 64'd1);

    ctrl_state_t state_d, state_q;

    logic [NUM_LINES-1:0] sync_v, prev_v, pend_v;
    logic [REG_W-1:0]     wdata_m, pend_w, in_w;
    logic                 hit_dir, hit_in, hit_set, hit_clr, hit_en;
    logic                 hit_typ, hit_pol, hit_pend, hit_mask;
    logic                 ack_wr;

    // views for the bound checker
    logic [NUM_LINES-1:0] en_bits, mask_bits, pend_bits;

    always_comb begin
        hit_dir  = (bus_addr == ADDR_W'(OFF_DIR));
        hit_in   = (bus_addr == ADDR_W'(OFF_IN));
        hit_set  = (bus_addr == ADDR_W'(OFF_SET));
        hit_clr  = (bus_addr == ADDR_W'(OFF_CLR));
        hit_en   = (bus_addr == ADDR_W'(OFF_EN));
        hit_typ  = (bus_addr == ADDR_W'(OFF_TYPE));
        hit_pol  = (bus_addr == ADDR_W'(OFF_POL));
        hit_pend = (bus_addr == ADDR_W'(OFF_PEND));
        hit_mask = (bus_addr == ADDR_W'(OFF_MASK));
        wdata_m  = bus_wdata & LINE_MASK;
        ack_wr   = bus_we & hit_pend;
    end

    gpio_in_sync #(
        .WIDTH (NUM_LINES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        gpio_irq_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_i  (sync_v[g]),
            .prev_i  (prev_v[g]),
            .en_i    (state_q.en[g]),
            .level_i (state_q.typ[g]),
            .pol_i   (state_q.pol[g]),
            .ack_i   (ack_wr & bus_wdata[g]),
            .pend_o  (pend_v[g])
        );
    end

    always_comb begin
        pend_w = REG_W'(pend_v);
        in_w   = REG_W'(sync_v);

        state_d = state_q;

        if (bus_we) begin
            if (hit_dir)  state_d.dir  = wdata_m;
            if (hit_set)  state_d.outl = state_q.outl | wdata_m;
            if (hit_clr)  state_d.outl = state_q.outl & ~wdata_m;
            if (hit_en)   state_d.en   = wdata_m;
            if (hit_typ)  state_d.typ  = wdata_m;
            if (hit_pol)  state_d.pol  = wdata_m;
            if (hit_mask) state_d.mask = wdata_m;
        end

        if (bus_re) begin
            state_d.rdata = '0;
            if (hit_dir)            state_d.rdata = state_q.dir;
            if (hit_in)             state_d.rdata = in_w;
            if (hit_set || hit_clr) state_d.rdata = state_q.outl;
            if (hit_en)             state_d.rdata = state_q.en;
            if (hit_typ)            state_d.rdata = state_q.typ;
            if (hit_pol)            state_d.rdata = state_q.pol;
            if (hit_pend)           state_d.rdata = pend_w;
            if (hit_mask)           state_d.rdata = state_q.mask;
        end

        state_d.irq = |(pend_w & state_q.en & state_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        bus_rdata = state_q.rdata;
        pin_out   = state_q.outl[NUM_LINES-1:0];
        if (DIR_INVERT) begin
            pin_oe = ~state_q.dir[NUM_LINES-1:0];
        end else begin
            pin_oe = state_q.dir[NUM_LINES-1:0];
        end
        irq_out   = state_q.irq;
        en_bits   = state_q.en[NUM_LINES-1:0];
        mask_bits = state_q.mask[NUM_LINES-1:0];
        pend_bits = pend_v;
    end

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter bit DIR_INVERT = 1'b0,
    parameter int ADDR_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] pin_out,
    input logic [NUM_LINES-1:0] pin_oe,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] en_bits,
    input logic [NUM_LINES-1:0] mask_bits,
    input logic [NUM_LINES-1:0] pend_bits
);

    logic [NUM_LINES-1:0] wd_n;
    assign wd_n = bus_wdata[NUM_LINES-1:0];

    // R2
    a_r2_dir_sense: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_DIR)) |=>
        (pin_oe == (DIR_INVERT ? ~$past(wd_n) : $past(wd_n))));

    // R3
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SET)) |=>
        ((pin_out & $past(wd_n)) == $past(wd_n)));

    // R4
    a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CLR)) |=>
        ((pin_out & $past(wd_n)) == '0));

    // R8
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_bits & ~en_bits) == '0));

    // R9
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|(pend_bits & en_bits & mask_bits)));

    // R9
    a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_bits & en_bits & mask_bits)) |=> irq_out);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NUM_LINES  (NUM_LINES),
    .DIR_INVERT (DIR_INVERT),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out),
    .en_bits   (en_bits),
    .mask_bits (mask_bits),
    .pend_bits (pend_bits)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [N-1:0] pins = '0;

    logic [31:0]  rdata, rdata_i;
    logic [N-1:0] pout, poe, pout_i, poe_i;
    logic         irq, irq_i;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl #(.NUM_LINES(N), .DIR_INVERT(1'b0), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata),
        .pin_in(pins), .pin_out(pout), .pin_oe(poe), .irq_out(irq));

    gpio_irq_ctrl #(.NUM_LINES(N), .DIR_INVERT(1'b1), .ADDR_W(8)) uut_inv (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata_i),
        .pin_in(pins), .pin_out(pout_i), .pin_oe(poe_i), .irq_out(irq_i));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  offs [9];
        offs = '{8'h00, 8'h04, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24};

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10 reset state
        for (int k = 0; k < 9; k++) begin
            rd(offs[k], v);
            chk("R10 reset register", v, 32'h0);
        end
        chk("R10 reset pin_out", 32'(pout), 32'h0);
        chk("R10 reset irq", 32'(irq), 32'h0);
        chk("R10 reset oe normal", 32'(poe), 32'h0);
        chk("R10 reset oe inverted", 32'(poe_i), 32'hFF);

        // R1 unmapped offsets read zero
        rd(8'h08, v); chk("R1 unmapped 0x08", v, 32'h0);
        rd(8'h28, v); chk("R1 unmapped 0x28", v, 32'h0);
        rd(8'hFC, v); chk("R1 unmapped 0xFC", v, 32'h0);

        // R2 direction sense, both variants
        for (int d = 0; d < 256; d += 37) begin
            wr(8'h00, 32'hFFFF_FF00 | 32'(d));
            chk("R2 oe normal", 32'(poe), 32'(d));
            chk("R2 oe inverted", 32'(poe_i), 32'(~d & 8'hFF));
            rd(8'h00, v);
            chk("R1 dir readback masked", v, 32'(d));
        end

        // R3/R4 set and clear over every latch pattern
        for (int s = 0; s < 256; s++) begin
            logic [7:0] c;
            c = 8'(s) ^ 8'h5A;
            wr(8'h10, 32'hFF);
            wr(8'h0C, 32'(s));
            chk("R3 set pattern", 32'(pout), 32'(s));
            wr(8'h0C, 32'h0);
            chk("R3 set zero keeps", 32'(pout), 32'(s));
            wr(8'h10, 32'(c));
            chk("R4 clear pattern", 32'(pout), 32'(8'(s) & ~c));
            rd(8'h0C, v);
            chk("R3 set offset reads latch", v, 32'(8'(s) & ~c));
            rd(8'h10, v);
            chk("R3 clear offset reads latch", v, 32'(8'(s) & ~c));
        end
        wr(8'h10, 32'hFF);
        wr(8'h0C, 32'hFFFF_FF00);
        chk("R1 set upper bits ignored", 32'(pout), 32'h0);

        // R5 input readback, exhaustive
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            pins = 8'(p);
            idle(3);
            rd(8'h04, v);
            chk("R5 input readback", v, 32'(p));
        end
        @(negedge clk);
        pins = '0;
        idle(4);

        // R6/R7/R9 every line in every type/polarity combination
        for (int i = 0; i < N; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic t, pl;
                logic [31:0] bit_i;
                t = m[1];
                pl = m[0];
                bit_i = 32'h1 << i;
                @(negedge clk);
                pins = '0;
                pins[i] = ~pl;
                idle(4);
                wr(8'h14, 32'h0);
                wr(8'h18, t ? bit_i : 32'h0);
                wr(8'h1C, pl ? bit_i : 32'h0);
                wr(8'h24, bit_i);
                wr(8'h14, bit_i);
                wr(8'h20, 32'hFF);
                idle(2);
                rd(8'h20, v);
                chk(t ? "R6 level idle pending" : "R7 edge idle pending", v, 32'h0);
                chk("R9 idle irq", 32'(irq), 32'h0);
                @(negedge clk);
                pins[i] = pl;
                idle(5);
                rd(8'h20, v);
                chk(t ? "R6 level active pending" : "R7 edge detected pending", v, bit_i);
                chk("R9 irq asserted", 32'(irq), 32'h1);
                if (t) begin
                    wr(8'h20, bit_i);
                    idle(2);
                    rd(8'h20, v);
                    chk("R6 level not clearable", v, bit_i);
                    @(negedge clk);
                    pins[i] = ~pl;
                    idle(5);
                    rd(8'h20, v);
                    chk("R6 level follows pin", v, 32'h0);
                    chk("R9 irq drops with level", 32'(irq), 32'h0);
                end else begin
                    idle(3);
                    rd(8'h20, v);
                    chk("R7 edge pending holds", v, bit_i);
                    wr(8'h20, bit_i);
                    idle(2);
                    rd(8'h20, v);
                    chk("R7 edge acknowledged", v, 32'h0);
                    chk("R9 irq drops after ack", 32'(irq), 32'h0);
                    @(negedge clk);
                    pins[i] = ~pl;
                    idle(5);
                    rd(8'h20, v);
                    chk("R7 opposite edge ignored", v, 32'h0);
                end
                wr(8'h14, 32'h0);
            end
        end

        // R8 disabled line ignores an edge
        @(negedge clk);
        pins = '0;
        idle(4);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h1);
        wr(8'h24, 32'h1);
        wr(8'h14, 32'h0);
        @(negedge clk);
        pins[0] = 1'b1;
        idle(5);
        rd(8'h20, v);
        chk("R8 disabled no pending", v, 32'h0);
        chk("R8 disabled no irq", 32'(irq), 32'h0);
        wr(8'h14, 32'h1);
        idle(3);
        rd(8'h20, v);
        chk("R8 no edge captured while off", v, 32'h0);
        // latched edge dropped on disable
        @(negedge clk);
        pins[0] = 1'b0;
        idle(2);
        @(negedge clk);
        pins[0] = 1'b1;
        idle(5);
        rd(8'h20, v);
        chk("R8 edge latched when on", v, 32'h1);
        wr(8'h14, 32'h0);
        wr(8'h14, 32'h1);
        idle(2);
        rd(8'h20, v);
        chk("R8 disable drops latched edge", v, 32'h0);

        // R9 mask gates only the output
        wr(8'h14, 32'h0);
        @(negedge clk);
        pins = '0;
        idle(4);
        wr(8'h18, 32'h0);
        wr(8'h1C, 32'h8);
        wr(8'h24, 32'h0);
        wr(8'h14, 32'h8);
        @(negedge clk);
        pins[3] = 1'b1;
        idle(5);
        rd(8'h20, v);
        chk("R9 masked line still pending", v, 32'h8);
        chk("R9 masked line no irq", 32'(irq), 32'h0);
        wr(8'h24, 32'h8);
        idle(2);
        chk("R9 unmask raises irq", 32'(irq), 32'h1);

        done = 1'b1;
        finish_run();
    end

endmodule